// File: doc/BRIEF.md
# Handshaked Iterative Shifter

This block shifts a data word by a requested number of bit positions, one position per clock cycle, behind a valid/ready handshake on each side. A producer offers a word, a shift amount and a direction bit. When the unit is idle, it accepts them. It then steps a state machine until the requested count is used up, and presents the result. The result stays on the output until a consumer takes it.

The controller has three states. In `IDLE` it waits for work and is the only state that accepts input. In `SHIFT` it moves the word one bit per cycle. In `HOLD` it presents the result and waits for the consumer.

The transitions are named as follows:
- `take_long` goes from `IDLE` to `SHIFT`. It happens on an accepted input whose amount is between 1 and width minus 1.
- `take_short` goes from `IDLE` to `HOLD`. It happens on an accepted input whose amount is 0 or at least the width.
- `last_step` goes from `SHIFT` to `HOLD`. It happens when the remaining count is 1.
- `drain` goes from `HOLD` to `IDLE`. It happens when the consumer signals ready.

Top module: `shf_iter_unit`

## Requirements
- R1: `in_ready` is high only in the idle state. It is low from the edge that accepts an input until the edge that completes the output handshake.
- R2: An input is accepted on a rising edge where `in_valid` and `in_ready` are both high. Data, amount and direction are captured there. Later input changes, and `in_valid` held high while busy, do not alter the pending result.
- R3: With `in_dir` = 1 the word is shifted right logically, and zeros enter at the top. For example, 13 shifted right by 2 gives 3.
- R4: With `in_dir` = 0 the word is shifted left, and bits shifted past the top are lost. For example, 3 shifted left by 4 gives 48 at an 8-bit width.
- R5: An amount of 0 returns the data unchanged in either direction. `out_valid` is high after the accepting edge itself.
- R6: An amount equal to or above `DATA_W` returns zero. `out_valid` is high after the accepting edge itself.
- R7: For an amount N from 1 to `DATA_W`-1, `out_valid` first goes high N edges after the accepting edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: An edge with `out_valid` and `out_ready` both high ends the result. After that edge, `out_valid` is low and `in_ready` is high.
- R10: After reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Unit is idle and will accept |
| in_data | input | DATA_W | Word to shift |
| in_amt | input | AMT_W | Number of bit positions |
| in_dir | input | 1 | 1 = logical right, 0 = left |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DATA_W | Shifted word |

## Verification
The shifter is driven with:
- amounts of 0 in both directions, which separate the direct path from the stepping path;
- mid-range amounts both ways, including a pattern with both end bits set, which shows zero fill on the correct side and loss of bits off the end;
- an amount equal to the width and a much larger amount, which show that oversize shifts are forced to zero rather than wrapped through a truncated counter.

Each result's arrival cycle is compared with the amount-dependent latency. This catches a count that is off by one. Items are offered back to back while the consumer holds off for varying times. This shows that a busy unit ignores new offers and that the held output does not drift.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } shf_state_e;

endpackage

// File: rtl/shf_amt_decode.sv
module shf_amt_decode #(
    parameter int DATA_W = 8,
    parameter int AMT_W  = 8
) (
    input  logic [AMT_W-1:0] amt,
    output logic             amt_zero,
    output logic             amt_big
);
    localparam logic [AMT_W:0] WIDTH_EXT = (AMT_W+1)'(DATA_W);

    always_comb begin
        amt_zero = (amt == '0);
        amt_big  = ({1'b0, amt} >= WIDTH_EXT);
    end
endmodule

// File: rtl/shf_ctrl.sv
module shf_ctrl
    import shf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    input  logic short_path,
    input  logic last_step,
    output logic in_ready,
    output logic out_valid,
    output logic load,
    output logic step
);
    shf_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = short_path ? ST_HOLD : ST_SHIFT;
            ST_SHIFT: if (last_step) state_d = ST_HOLD;
            ST_HOLD:  if (out_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load      = 1'b0;
        step      = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin in_ready = 1'b1; load = in_valid; end
            ST_SHIFT: step = 1'b1;
            ST_HOLD:  out_valid = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/shf_datapath.sv
module shf_datapath #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [CNT_W-1:0]  ld_cnt,
    input  logic              ld_dir,
    input  logic              ld_clear,
    output logic              last_step,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] word_q, stepped;
    logic [CNT_W-1:0]  cnt_q;
    logic              dir_q;

    // one-position move, per bit
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic from_low, from_high;
        if (i == 0) begin : g_lo
            assign from_low = 1'b0;
        end else begin : g_lo
            assign from_low = word_q[i-1];
        end
        if (i == DATA_W-1) begin : g_hi
            assign from_high = 1'b0;
        end else begin : g_hi
            assign from_high = word_q[i+1];
        end
        assign stepped[i] = dir_q ? from_high : from_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
            dir_q  <= 1'b0;
        end else if (load) begin
            word_q <= ld_clear ? '0 : ld_data;
            cnt_q  <= ld_clear ? '0 : ld_cnt;
            dir_q  <= ld_dir;
        end else if (step) begin
            word_q <= stepped;
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    assign last_step = (cnt_q == CNT_W'(1));
    assign word      = word_q;
endmodule

// File: rtl/shf_iter_unit.sv
module shf_iter_unit #(
    parameter int DATA_W = 8,
    parameter int AMT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [AMT_W-1:0]  in_amt,
    input  logic              in_dir,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    logic amt_zero, amt_big, load, step, last_step;

    shf_amt_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
        .amt      (in_amt),
        .amt_zero (amt_zero),
        .amt_big  (amt_big)
    );

    shf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .out_ready  (out_ready),
        .short_path (amt_zero | amt_big),
        .last_step  (last_step),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .load       (load),
        .step       (step)
    );

    shf_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .ld_data   (in_data),
        .ld_cnt    (in_amt[CNT_W-1:0]),
        .ld_dir    (in_dir),
        .ld_clear  (amt_big),
        .last_step (last_step),
        .word      (out_data)
    );
endmodule

// File: rtl/shf_iter_unit_chk.sv
module shf_iter_unit_chk #(
    parameter int DATA_W = 8,
    parameter int AMT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic [AMT_W-1:0]  in_amt,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    localparam logic [AMT_W:0] WIDTH_EXT = (AMT_W+1)'(DATA_W);

    // R1
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R5
    zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_amt == '0) |=> (out_valid && out_data == $past(in_data)));

    // R6
    big_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ({1'b0, in_amt} >= WIDTH_EXT)) |=> (out_valid && out_data == '0));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

bind shf_iter_unit shf_iter_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_amt    (in_amt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/shf_iter_unit_test.sv
`timescale 1ns/1ps
module shf_iter_unit_test;
    localparam int W = 8;
    localparam int A = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic [A-1:0] in_amt = '0;
    logic         in_dir = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [W-1:0] q_data[$];
    int           q_cyc[$];
    int           q_hold[$];
    string        q_tag[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shf_iter_unit #(.DATA_W(W), .AMT_W(A)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_amt(in_amt), .in_dir(in_dir),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(string req, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(logic [W-1:0] d, int amt, bit dir);
        if (amt >= W) return '0;
        return dir ? (d >> amt) : (d << amt);
    endfunction

    task automatic send(logic [W-1:0] d, int amt, bit dir, int hold, string tag);
        int n;
        n = (amt >= W) ? 0 : amt;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_amt = A'(amt); in_dir = dir;
        while (!in_ready) @(negedge clk);
        q_data.push_back(model(d, amt, dir));
        q_cyc.push_back(cyc + 1 + n);
        q_hold.push_back(hold);
        q_tag.push_back(tag);
        @(posedge clk);
        #1;
        in_data = ~d; in_amt = A'(3); in_dir = ~dir;
        @(negedge clk);
        // R1: busy after accept; R2 later inputs ignored via final result
        check("R1", in_ready == 1'b0, int'(in_ready), 0);
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (q_data.size() == 0) begin
                    check("R2", 1'b0, 1, 0);
                end else begin
                    logic [W-1:0] ed;
                    int ec, hold;
                    string tag;
                    ed = q_data.pop_front();
                    ec = q_cyc.pop_front();
                    hold = q_hold.pop_front();
                    tag = q_tag.pop_front();
                    check({tag, " data"}, out_data == ed, int'(out_data), int'(ed));
                    check({tag, " latency R7"}, cyc == ec, cyc, ec);
                    for (int i = 0; i < hold; i++) begin
                        @(negedge clk);
                        check("R8", out_valid && out_data == ed, int'(out_data), int'(ed));
                    end
                    out_ready = 1'b1;
                    @(negedge clk);
                    out_ready = 1'b0;
                    check("R9 valid", !out_valid, int'(out_valid), 0);
                    check("R9 ready", in_ready, int'(in_ready), 1);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 ready", in_ready == 1'b1, int'(in_ready), 1);
        check("R10 valid", out_valid == 1'b0, int'(out_valid), 0);

        send(8'd13,   2,   1'b1, 0, "R3");
        send(8'd3,    4,   1'b0, 2, "R4");
        send(8'd21,   0,   1'b0, 1, "R5");
        send(8'd21,   0,   1'b1, 0, "R5");
        send(8'h81,   7,   1'b1, 3, "R3");
        send(8'h81,   7,   1'b0, 1, "R4");
        send(8'hA5,   1,   1'b0, 0, "R4");
        send(8'hA5,   3,   1'b1, 2, "R3");
        send(8'hFF,   8,   1'b0, 1, "R6");
        send(8'hFF,   200, 1'b1, 0, "R6");
        send(8'h5A,   1,   1'b1, 4, "R7");

        while (q_data.size() != 0 || !in_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule